// File: doc/BRIEF.md
# SPI Peripheral with Split Receive/Transmit Buffer

This block is the target side of an SPI link. It is backed by a single byte buffer that is cut into two equal halves. The lower half is a receive queue and the upper half is a transmit queue. While chip select is low, the serial engine packs incoming bits into bytes and appends them to the receive queue. It takes outgoing bytes from the transmit queue and drives them on the data-out line. The clock polarity and sampling phase come from a two-bit mode field.

Each queue has two pointers, and they are owned by different sides. The serial side advances the receive write pointer and the transmit read pointer. The processor side owns the receive read pointer and the transmit write pointer, which it sets through registers. Each pointer is one bit wider than the queue index, so a full queue can be told apart from an empty one. The processor reaches both queues through address windows. Reads from the windows may be any width. Writes are taken only as whole 32-bit words.

The serial side cannot be stalled, so there is no back-pressure toward the SPI master. When the transmit queue is empty, an idle byte is sent. When the receive queue is full, incoming bytes are discarded. Both cases leave a sticky mark in the status register. The processor port never stalls: it accepts one access per cycle, and read data is returned with `cpu_rvalid` one cycle later. Parameter `AW` sets the queue index width (default 10, giving 1 KB per queue). `AW` must be at least 5 so that the register region can hold all eight registers.

Top module: `spi_dual_fifo_slave`

## Requirements
- R1: After reset, all four pointers are 0, every sticky status bit is clear, `irq` and `spi_miso_oe` are low, and STATUS reads 0xA0 (both queues empty).
- R2: `spi_miso_oe` is high only while chip select is active (low). Otherwise the data-out line is released to high impedance.
- R3: MODE[1] is clock polarity and MODE[0] is phase. Mode 0 samples on the rising edge, mode 1 on the falling edge, mode 2 on the falling edge and mode 3 on the rising edge. Data moves most significant bit first in both directions.
- R4: Each received byte is stored at receive index `rxwr[AW-1:0]`, and `rxwr` then steps by one. Pointers are AW+1 bits wide and carry a wrap bit in the top position.
- R5: The receive queue is full when the low AW pointer bits match and the wrap bits differ. A byte that arrives while the queue is full is discarded, and STATUS bit 1 (overflow) is set.
- R6: Outgoing bytes come from transmit index `txrd[AW-1:0]`. `txrd` steps once the first bit of the byte has been sampled. If the queue is empty when a byte is loaded, 0xFF is sent, `txrd` stays put and STATUS bit 0 (underrun) is set.
- R7: Writes to either queue window are accepted only when size is word (code 2). Narrower window writes change nothing and pulse `cpu_err` together with `cpu_rvalid` timing. Bytes are little-endian within a word.
- R8: Window reads may be byte (0), halfword (1) or word (2). The result is zero-extended and aligned down to its size.
- R9: Registers are at byte offsets 0 MODE, 4 RXRD, 8 RXWR, 12 TXWR, 16 TXRD, 20 STATUS, 24 THRESH and 28 LEVEL. Writes to RXWR and TXRD are ignored.
- R10: STATUS bits 0 to 3 are sticky and cleared by writing 1: underrun, overflow, select start and select end. The remaining bits are live: bit 4 select active, bit 5 rx empty, bit 6 rx full, bit 7 tx empty, bit 8 tx full.
- R11: `irq` is high while the select-end sticky bit is set, or while THRESH is nonzero and the receive level is at least THRESH.
- R12: LEVEL reads the transmit fill in bits 31:16 and the receive fill in bits 15:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for serial data out |
| cpu_valid | input | 1 | Processor access strobe |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | AW+2 | Byte address: region in top two bits (0 registers, 1 rx window, 2 tx window) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after the read |
| cpu_err | output | 1 | Rejected narrow window write |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `AW = 5`, which gives 32-byte queues in a 64-byte buffer. With that size, 33 bytes in one transfer fill the receive queue and push one byte into overflow. The same pass drives the receive write pointer across its wrap bit, which reaches both the full test and the wrap rule in about five thousand clocks. A table of single-byte transfers runs each of the four clock modes twice with distinct data in both directions. Directed cases then cover the idle byte, narrow writes, mixed-width reads, read-only pointers and the threshold interrupt.

// File: rtl/spis_pkg.sv
package spis_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    RG_CTRL  = 2'd0,
    RG_RXWIN = 2'd1,
    RG_TXWIN = 2'd2,
    RG_NONE  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    R_MODE  = 3'd0,
    R_RXRD  = 3'd1,
    R_RXWR  = 3'd2,
    R_TXWR  = 3'd3,
    R_TXRD  = 3'd4,
    R_STAT  = 3'd5,
    R_THR   = 3'd6,
    R_LVL   = 3'd7
  } reg_idx_e;

  localparam logic [7:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spis_ptr_stat.sv
module spis_ptr_stat #(
  parameter int PW = 11
) (
  input  logic [PW-1:0] wr,
  input  logic [PW-1:0] rd,
  output logic [PW-1:0] level,
  output logic          full,
  output logic          empty
);
  always_comb begin
    empty = (wr == rd);
    full  = (wr[PW-2:0] == rd[PW-2:0]) && (wr[PW-1] != rd[PW-1]);
    level = wr - rd;
  end
endmodule

// File: rtl/spis_engine.sv
module spis_engine
  import spis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic       tx_empty,
  input  logic [7:0] tx_data,
  output logic       cs_act,
  output logic       cs_start,
  output logic       cs_end,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       tx_take,
  output logic       tx_idle_hit,
  output logic       miso
);
  logic       sck_d, cs_prev, idle_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       rise, fall, lead, trail, samp, shft, load;

  always_comb begin
    cs_act   = ~cs_n;
    cs_start = cs_act & ~cs_prev;
    cs_end   = ~cs_act & cs_prev;
    rise     = sck & ~sck_d;
    fall     = ~sck & sck_d;
    lead     = cpol ? fall : rise;
    trail    = cpol ? rise : fall;
    samp     = cs_act & (cpha ? trail : lead);
    shft     = cs_act & (cpha ? lead : trail);
    // a byte is staged at select start and at the shift edge that opens a byte
    load     = cs_start | (shft & (bit_cnt == 3'd0));
    rx_valid = samp & (bit_cnt == 3'd7);
    rx_data  = {rx_sh, mosi};
    tx_take     = samp & (bit_cnt == 3'd0) & ~idle_q;
    tx_idle_hit = samp & (bit_cnt == 3'd0) & idle_q;
    miso     = tx_sh[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      cs_prev <= 1'b0;
      bit_cnt <= 3'd0;
      rx_sh   <= 7'd0;
      tx_sh   <= IDLE_BYTE;
      idle_q  <= 1'b1;
    end else begin
      sck_d   <= sck;
      cs_prev <= cs_act;
      if (!cs_act) begin
        bit_cnt <= 3'd0;
      end else if (samp) begin
        bit_cnt <= bit_cnt + 3'd1;
        rx_sh   <= {rx_sh[5:0], mosi};
      end
      if (load) begin
        tx_sh  <= tx_empty ? IDLE_BYTE : tx_data;
        idle_q <= tx_empty;
      end else if (shft) begin
        tx_sh  <= {tx_sh[6:0], 1'b1};
      end
    end
  end

  // R3: bit position restarts whenever the select is idle
  a_r3_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/spi_dual_fifo_slave.sv
module spi_dual_fifo_slave
  import spis_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_size,
  input  logic [AW+1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic          cpu_rvalid,
  output logic          cpu_err,
  output logic          irq
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int CA    = AW + 2;

  logic          sck_s, csn_s, mosi_s;
  logic [1:0]    mode;
  logic [PW-1:0] rx_wr, rx_rd, tx_wr, tx_rd, thr;
  logic [PW-1:0] rx_level, tx_level;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          cs_act, cs_start, cs_end, rx_valid, tx_take, tx_idle_hit;
  logic [7:0]    rx_data, tx_peek;
  logic          st_txe, st_ovf, st_start, st_end;
  logic [7:0]    mem [2*DEPTH];

  spis_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_mosi}),
    .q({sck_s, csn_s, mosi_s}));

  spis_ptr_stat #(.PW(PW)) u_rx_stat (
    .wr(rx_wr), .rd(rx_rd), .level(rx_level), .full(rx_full), .empty(rx_empty));
  spis_ptr_stat #(.PW(PW)) u_tx_stat (
    .wr(tx_wr), .rd(tx_rd), .level(tx_level), .full(tx_full), .empty(tx_empty));

  assign tx_peek = mem[{1'b1, tx_rd[AW-1:0]}];

  spis_engine u_engine (
    .clk(clk), .rst_n(rst_n), .cpol(mode[1]), .cpha(mode[0]),
    .sck(sck_s), .cs_n(csn_s), .mosi(mosi_s),
    .tx_empty(tx_empty), .tx_data(tx_peek),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_take(tx_take), .tx_idle_hit(tx_idle_hit), .miso(spi_miso));

  assign spi_miso_oe = cs_act;

  // processor access decode
  region_e       region;
  reg_idx_e      ridx;
  logic [AW-1:0] off, base_off;
  logic          wr_acc, reg_wr, win_wr_ok, win_narrow, rx_push;
  logic [3:0]    clr;
  logic [7:0]    rb [4];
  logic [31:0]   win_data, reg_data, rd_mux;

  always_comb begin
    region     = region_e'(cpu_addr[CA-1:AW]);
    ridx       = reg_idx_e'(cpu_addr[4:2]);
    off        = cpu_addr[AW-1:0];
    wr_acc     = cpu_valid & cpu_we;
    reg_wr     = wr_acc & (region == RG_CTRL);
    win_wr_ok  = wr_acc & (region == RG_TXWIN) & (cpu_size == SZ_WORD);
    win_narrow = wr_acc & ((region == RG_TXWIN) | (region == RG_RXWIN)) &
                 (cpu_size != SZ_WORD);
    clr        = (reg_wr && ridx == R_STAT) ? cpu_wdata[3:0] : 4'd0;
    rx_push    = rx_valid & ~rx_full;
    irq        = st_end | ((thr != '0) && (rx_level >= thr));

    case (cpu_size)
      SZ_WORD: base_off = {off[AW-1:2], 2'b00};
      SZ_HALF: base_off = {off[AW-1:1], 1'b0};
      default: base_off = off;
    endcase
    for (int k = 0; k < 4; k++)
      rb[k] = mem[{(region == RG_TXWIN), base_off + AW'(k)}];
    case (cpu_size)
      SZ_WORD: win_data = {rb[3], rb[2], rb[1], rb[0]};
      SZ_HALF: win_data = {16'd0, rb[1], rb[0]};
      default: win_data = {24'd0, rb[0]};
    endcase

    case (ridx)
      R_MODE:  reg_data = {30'd0, mode};
      R_RXRD:  reg_data = 32'(rx_rd);
      R_RXWR:  reg_data = 32'(rx_wr);
      R_TXWR:  reg_data = 32'(tx_wr);
      R_TXRD:  reg_data = 32'(tx_rd);
      R_STAT:  reg_data = {23'd0, tx_full, tx_empty, rx_full, rx_empty, cs_act,
                           st_end, st_start, st_ovf, st_txe};
      R_THR:   reg_data = 32'(thr);
      default: reg_data = {16'(tx_level), 16'(rx_level)};
    endcase

    case (region)
      RG_CTRL:  rd_mux = reg_data;
      RG_RXWIN,
      RG_TXWIN: rd_mux = win_data;
      default:  rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'd0;  thr <= '0;
      rx_wr <= '0;  rx_rd <= '0;  tx_wr <= '0;  tx_rd <= '0;
      st_txe <= 1'b0;  st_ovf <= 1'b0;  st_start <= 1'b0;  st_end <= 1'b0;
      cpu_rdata <= 32'd0;  cpu_rvalid <= 1'b0;  cpu_err <= 1'b0;
    end else begin
      if (rx_push) rx_wr <= rx_wr + PW'(1);
      if (tx_take) tx_rd <= tx_rd + PW'(1);
      if (reg_wr) begin
        case (ridx)
          R_MODE:  mode  <= cpu_wdata[1:0];
          R_RXRD:  rx_rd <= cpu_wdata[PW-1:0];
          R_TXWR:  tx_wr <= cpu_wdata[PW-1:0];
          R_THR:   thr   <= cpu_wdata[PW-1:0];
          default: ;
        endcase
      end
      st_txe   <= (st_txe   & ~clr[0]) | tx_idle_hit;
      st_ovf   <= (st_ovf   & ~clr[1]) | (rx_valid & rx_full);
      st_start <= (st_start & ~clr[2]) | cs_start;
      st_end   <= (st_end   & ~clr[3]) | cs_end;
      cpu_rvalid <= cpu_valid & ~cpu_we;
      cpu_rdata  <= rd_mux;
      cpu_err    <= win_narrow;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push) mem[{1'b0, rx_wr[AW-1:0]}] <= rx_data;
    if (win_wr_ok)
      for (int k = 0; k < 4; k++)
        mem[{1'b1, off[AW-1:2], 2'(k)}] <= cpu_wdata[8*k +: 8];
  end

  // R4: the hardware receive pointer moves by at most one per cycle
  a_r4_rxwr_step: assert property (@(posedge clk) disable iff (!rst_n)
    PW'(rx_wr - $past(rx_wr)) <= PW'(1));
  // R5: nothing is stored while the receive queue is full
  a_r5_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_wr));
  // R5: fill level never exceeds the queue depth
  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= PW'(DEPTH));
  // R6: the transmit read pointer stays put while the queue is empty
  a_r6_txrd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |=> $stable(tx_rd));
  // R10: overflow mark persists until written with one
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ovf && !clr[1]) |=> st_ovf);
  // R11: end of a select raises the interrupt
  a_r11_irq_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> irq);
endmodule

// File: tb/spi_dual_fifo_slave_bench.sv
`timescale 1ns/1ps
module spi_dual_fifo_slave_bench;
  localparam int AW = 5;
  localparam int RXB = 32;
  localparam int TXB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso, spi_miso_oe;
  logic        cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [AW+1:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = 32'd0;
  logic [31:0] cpu_rdata;
  logic        cpu_rvalid, cpu_err, irq;

  always #2 clk = ~clk;

  spi_dual_fifo_slave #(.AW(AW)) u_spi_dual_fifo_slave (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .cpu_err(cpu_err), .irq(irq));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic cpol = 1'b0, cpha = 1'b0, oe_during;
  logic [7:0] mo_buf [64];
  logic [7:0] mi_buf [64];
  logic [5:0] e_rxrd = '0, e_rxwr = '0, e_txwr = '0, e_txrd = '0;
  logic [31:0] rd;
  logic        er;

  // mode, master byte, queued transmit byte
  localparam logic [17:0] VECS [8] = '{
    {2'd0, 8'hA5, 8'h3C}, {2'd1, 8'h5A, 8'hC3}, {2'd2, 8'h81, 8'h7E},
    {2'd3, 8'h01, 8'h80}, {2'd0, 8'hFE, 8'h12}, {2'd1, 8'h00, 8'hE7},
    {2'd2, 8'h69, 8'h96}, {2'd3, 8'hC0, 8'h0F}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_acc(input logic we, input logic [1:0] sz, input int addr,
                         input logic [31:0] wd, output logic [31:0] r, output logic e);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_size = sz;
    cpu_addr = (AW+2)'(addr); cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
    r = cpu_rdata; e = cpu_err;
  endtask

  task automatic spi_xfer(input int n);
    spi_sck = cpol; #80; spi_cs_n = 1'b0; #80;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (!cpha) begin
          spi_mosi = mo_buf[b][i]; #40; spi_sck = ~cpol;
          mi_buf[b][i] = spi_miso; #40; spi_sck = cpol;
        end else begin
          #40; spi_sck = ~cpol; spi_mosi = mo_buf[b][i];
          #40; spi_sck = cpol; mi_buf[b][i] = spi_miso;
        end
      end
    end
    oe_during = spi_miso_oe;
    #80; spi_cs_n = 1'b1; #80;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cpol = m[1]; cpha = m[0];
    cpu_acc(1'b1, 2'd2, 0, {30'd0, m}, rd, er);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #20 rst_n = 1'b1;
    // R1: reset state
    check("R1 miso_oe", {31'd0, spi_miso_oe}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    cpu_acc(1'b0, 2'd2, 8, 0, rd, er);  check("R1 rxwr", rd, 32'd0);
    cpu_acc(1'b0, 2'd2, 16, 0, rd, er); check("R1 txrd", rd, 32'd0);
    cpu_acc(1'b0, 2'd2, 20, 0, rd, er); check("R1 status", rd, 32'h0A0);

    // table walk: R3 modes, R4 receive store, R6 transmit order
    foreach (VECS[v]) begin
      set_mode(VECS[v][17:16]);
      cpu_acc(1'b1, 2'd2, TXB + {e_txwr[4:2], 2'b00}, {4{VECS[v][7:0]}}, rd, er);
      e_txwr++;
      cpu_acc(1'b1, 2'd2, 12, 32'(e_txwr), rd, er);
      mo_buf[0] = VECS[v][15:8];
      spi_xfer(1);
      e_txrd++; e_rxwr++;
      check("R3 R6 miso byte", 32'(mi_buf[0]), 32'(VECS[v][7:0]));
      cpu_acc(1'b0, 2'd0, RXB + int'(e_rxrd[4:0]), 0, rd, er);
      check("R3 R4 mosi byte", rd, 32'(VECS[v][15:8]));
      e_rxrd++;
      cpu_acc(1'b1, 2'd2, 4, 32'(e_rxrd), rd, er);
      if (v == 0) check("R2 oe during select", {31'd0, oe_during}, 32'd1);
    end
    check("R2 oe idle", {31'd0, spi_miso_oe}, 32'd0);
    cpu_acc(1'b0, 2'd2, 8, 0, rd, er);  check("R4 rxwr after table", rd, 32'(e_rxwr));
    cpu_acc(1'b0, 2'd2, 16, 0, rd, er); check("R6 txrd after table", rd, 32'(e_txrd));

    // R6: empty transmit queue sends idle byte
    set_mode(2'd0);
    mo_buf[0] = 8'h11;
    spi_xfer(1);
    e_rxwr++;
    check("R6 idle byte", 32'(mi_buf[0]), 32'h0FF);
    cpu_acc(1'b0, 2'd2, 16, 0, rd, er); check("R6 txrd held", rd, 32'(e_txrd));
    cpu_acc(1'b0, 2'd2, 20, 0, rd, er); check("R6 underrun mark", rd & 32'h1, 32'h1);
    e_rxrd = e_rxwr;
    cpu_acc(1'b1, 2'd2, 4, 32'(e_rxrd), rd, er);

    // R10: write-one-to-clear
    cpu_acc(1'b1, 2'd2, 20, 32'hF, rd, er);
    cpu_acc(1'b0, 2'd2, 20, 0, rd, er); check("R10 cleared status", rd, 32'h0A0);
    check("R11 irq low after clear", {31'd0, irq}, 32'd0);

    // R11 / R12: threshold interrupt and level register
    cpu_acc(1'b1, 2'd2, 24, 32'd2, rd, er);
    mo_buf[0] = 8'h21; mo_buf[1] = 8'h22;
    spi_xfer(2);
    e_rxwr += 2;
    cpu_acc(1'b1, 2'd2, 20, 32'hF, rd, er);
    check("R11 irq at threshold", {31'd0, irq}, 32'd1);
    cpu_acc(1'b0, 2'd2, 28, 0, rd, er); check("R12 level", rd, 32'h2);
    e_rxrd++;
    cpu_acc(1'b1, 2'd2, 4, 32'(e_rxrd), rd, er);
    check("R11 irq below threshold", {31'd0, irq}, 32'd0);
    e_rxrd++;
    cpu_acc(1'b1, 2'd2, 4, 32'(e_rxrd), rd, er);
    cpu_acc(1'b1, 2'd2, 24, 32'd0, rd, er);

    // R5 / R4: overflow and wrap bit
    for (int b = 0; b < 33; b++) mo_buf[b] = 8'(8'h40 + b);
    spi_xfer(33);
    cpu_acc(1'b0, 2'd2, 28, 0, rd, er); check("R5 level full", rd, 32'h20);
    cpu_acc(1'b0, 2'd2, 8, 0, rd, er);
    check("R4 wrap pointer", rd, 32'(6'(e_rxwr + 6'd32)));
    cpu_acc(1'b0, 2'd2, 20, 0, rd, er); check("R5 overflow and full", rd & 32'h42, 32'h42);
    cpu_acc(1'b0, 2'd0, RXB + int'(e_rxrd[4:0]), 0, rd, er);
    check("R5 first byte kept", rd, 32'h40);
    cpu_acc(1'b0, 2'd0, RXB + int'(5'(e_rxrd[4:0] + 5'd31)), 0, rd, er);
    check("R5 last stored byte", rd, 32'h5F);
    e_rxwr += 32; e_rxrd = e_rxwr;
    cpu_acc(1'b1, 2'd2, 4, 32'(e_rxrd), rd, er);
    cpu_acc(1'b1, 2'd2, 20, 32'hF, rd, er);

    // R7: narrow window write rejected
    cpu_acc(1'b1, 2'd0, TXB + 4, 32'hAA, rd, er);
    check("R7 err on narrow write", {31'd0, er}, 32'd1);
    cpu_acc(1'b0, 2'd2, TXB + 4, 0, rd, er); check("R7 word unchanged", rd, 32'h0F0F0F0F);
    cpu_acc(1'b1, 2'd2, TXB + 12, 32'h44332211, rd, er);
    check("R7 no err on word write", {31'd0, er}, 32'd0);

    // R8: mixed-width window reads
    cpu_acc(1'b0, 2'd0, TXB + 14, 0, rd, er); check("R8 byte read", rd, 32'h33);
    cpu_acc(1'b0, 2'd0, TXB + 15, 0, rd, er); check("R8 top byte read", rd, 32'h44);
    cpu_acc(1'b0, 2'd1, TXB + 12, 0, rd, er); check("R8 half read", rd, 32'h2211);
    cpu_acc(1'b0, 2'd1, TXB + 15, 0, rd, er); check("R8 half aligned down", rd, 32'h4433);
    cpu_acc(1'b0, 2'd2, TXB + 13, 0, rd, er); check("R8 word read", rd, 32'h44332211);

    // R9: hardware pointers ignore writes
    cpu_acc(1'b1, 2'd2, 8, 32'd5, rd, er);
    cpu_acc(1'b0, 2'd2, 8, 0, rd, er);  check("R9 rxwr read-only", rd, 32'(e_rxwr));
    cpu_acc(1'b1, 2'd2, 16, 32'd3, rd, er);
    cpu_acc(1'b0, 2'd2, 16, 0, rd, er); check("R9 txrd read-only", rd, 32'(e_txrd));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule